// File: doc/BRIEF.md
# Flash Status Register and Identification Responder

This block sits behind the command decoder of a serial flash slave. It keeps the writable protection field of the status register and answers two kinds of read: the status read and the identification read. The decoder hands it one opcode at the start of each chip-select cycle on `op_valid`/`op_code`. It also passes every later byte of that cycle on `in_valid`/`in_data` and pulses `cyc_end` when chip enable goes high. The program engine supplies the live `busy_in` and `wel_in` flags. The protection field leaves the block on `prot_bits`.

Response bytes go to the serializer over a valid/ready stream (`so_valid`, `so_ready`, `so_data`). A byte moves only in a cycle where both valid and ready are high. While ready is low, the byte on offer holds still and nothing advances. A status stream is the exception: its flag bits follow the live inputs. A response stream has no length limit and runs until `cyc_end`. The input byte path has no back-pressure: every `in_valid` byte is taken in the cycle it is offered. `op_valid` and `cyc_end` never arrive in the same cycle.

A write to the status register is honoured only if the cycle just before it was the write-status enable cycle. Any other command in between cancels that permission.

Top module: `fsr_id_responder`

## Requirements
- R1: After reset, `so_valid` is 0 and `prot_bits` equals the parameter `PROT_RST`.
- R2: Opcode 05h makes `so_valid` high from the next cycle. Every accepted byte is the status byte until `cyc_end`. The status byte is laid out as bit 0 = BUSY, bit 1 = WEL, bits [2 +: PROT_W] = protection field, remaining upper bits 0 (PROT_W is 1 to 6).
- R3: BUSY and WEL in each status byte are the values of `busy_in` and `wel_in` in the cycle that byte is accepted.
- R4: Opcode 01h in the cycle right after a cycle whose opcode was 50h grants a status write. If at least one data byte arrives, then on `cyc_end` the field takes bits [2 +: PROT_W] of that byte, visible on `prot_bits` from the next cycle.
- R5: Opcode 01h without 50h in the directly preceding cycle leaves `prot_bits` unchanged.
- R6: Any opcode other than 01h after a 50h cycle cancels the permission, so a later 01h changes nothing.
- R7: Only the first data byte of a granted write counts. Its bits 0 and 1 and any bits above the field have no effect, and BUSY and WEL keep following the inputs.
- R8: A granted 01h cycle that ends with no data byte changes nothing and uses up the permission.
- R9: Opcode 90h takes ADDR_BYTES address bytes and then streams. The first byte is `MFR_ID` if bit 0 of the last address byte is 0, and `DEV_ID` (default 43h) if it is 1.
- R10: The identification stream alternates between the two IDs on every accepted byte until `cyc_end`.
- R11: While `so_ready` is low, the offered ID byte stays stable and the alternation does not advance.
- R12: The cycle after `cyc_end`, `so_valid` is 0. Opcodes other than 05h and 90h produce no stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Opcode of a new chip-select cycle is present |
| op_code | input | 8 | Decoded opcode |
| in_valid | input | 1 | A following byte of the cycle is present |
| in_data | input | 8 | Address or data byte |
| cyc_end | input | 1 | Chip enable has risen; cycle ends |
| busy_in | input | 1 | Live BUSY flag from the program engine |
| wel_in | input | 1 | Live write-enable latch flag |
| so_valid | output | 1 | Response byte offered |
| so_ready | input | 1 | Serializer takes the offered byte |
| so_data | output | 8 | Response byte |
| prot_bits | output | PROT_W | Protection field of the status register |

## Verification
The bench builds the block with a five-bit protection field, a reset value of 10101b and a manufacturer ID of A6h. With five bits, the field reaches bit 6, so the status byte shows all writable positions and only bit 7 stays zero. The mixed reset pattern makes any write that lands in the wrong place show up. A manufacturer ID that differs from the device ID in every nibble makes each step of the alternation visible, and it also shows a stall under back-pressure.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_EWSR = 8'h50;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_RDID = 8'h90;

  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_STAT  = 2'd1,
    M_IDADR = 2'd2,
    M_ID    = 2'd3
  } rsp_mode_e;
endpackage

// File: rtl/fsr_wsr_guard.sv
module fsr_wsr_guard
  import fsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [7:0] op_code,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       cyc_end,
  output logic       commit,
  output logic [7:0] commit_data
);
  logic       armed;
  logic       granted;
  logic       have_byte;
  logic [7:0] wbuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      granted   <= 1'b0;
      have_byte <= 1'b0;
      wbuf      <= '0;
    end else if (op_valid) begin
      armed     <= (op_code == OP_EWSR);
      granted   <= (op_code == OP_WRSR) && armed;
      have_byte <= 1'b0;
    end else if (cyc_end) begin
      granted   <= 1'b0;
      have_byte <= 1'b0;
    end else if (in_valid && granted && !have_byte) begin
      wbuf      <= in_data;
      have_byte <= 1'b1;
    end
  end

  assign commit      = cyc_end && granted && have_byte;
  assign commit_data = wbuf;

  // R4/R6: a grant only ever follows an armed state and a fresh opcode
  p_grant_needs_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(granted) |-> ($past(armed) && $past(op_valid)));

  // R7: once the first data byte is held, later bytes leave it alone
  p_first_byte_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (have_byte && in_valid && !op_valid && !cyc_end) |=> $stable(wbuf));
endmodule

// File: rtl/fsr_sr_regs.sv
module fsr_sr_regs #(
  parameter int unsigned       PROT_W   = 4,
  parameter logic [PROT_W-1:0] PROT_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [7:0]        commit_data,
  input  logic              busy_in,
  input  logic              wel_in,
  output logic [PROT_W-1:0] prot,
  output logic [7:0]        status_byte
);
  localparam int unsigned     PROT_LSB = 2;
  localparam logic [7:0]      WR_MASK  = 8'(((1 << PROT_W) - 1) << PROT_LSB);

  logic unused_wr;
  assign unused_wr = ^(commit_data & ~WR_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prot <= PROT_RST;
    else if (commit) prot <= commit_data[PROT_LSB +: PROT_W];
  end

  always_comb begin
    status_byte                     = '0;
    status_byte[0]                  = busy_in;
    status_byte[1]                  = wel_in;
    status_byte[PROT_LSB +: PROT_W] = prot;
  end

  // R5: the field moves only in the cycle after a commit from the guard
  p_prot_only_on_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prot != $past(prot)) |-> $past(commit));
endmodule

// File: rtl/fsr_rsp_stream.sv
module fsr_rsp_stream
  import fsr_pkg::*;
#(
  parameter logic [7:0]  MFR_ID     = 8'h5A,
  parameter logic [7:0]  DEV_ID     = 8'h43,
  parameter int unsigned ADDR_BYTES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [7:0] op_code,
  input  logic       in_valid,
  input  logic       in_a0,
  input  logic       cyc_end,
  input  logic [7:0] status_byte,
  input  logic       so_ready,
  output logic       so_valid,
  output logic [7:0] so_data
);
  localparam int unsigned CW = $clog2(ADDR_BYTES + 1);

  rsp_mode_e   mode;
  logic [CW-1:0] acnt;
  logic        sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_IDLE;
      acnt <= '0;
      sel  <= 1'b0;
    end else if (op_valid) begin
      acnt <= '0;
      case (op_code)
        OP_RDSR: mode <= M_STAT;
        OP_RDID: mode <= M_IDADR;
        default: mode <= M_IDLE;
      endcase
    end else if (cyc_end) begin
      mode <= M_IDLE;
    end else begin
      case (mode)
        M_IDADR: if (in_valid) begin
          if (acnt == CW'(ADDR_BYTES - 1)) begin
            mode <= M_ID;
            sel  <= in_a0;
          end else begin
            acnt <= acnt + 1'b1;
          end
        end
        M_ID: if (so_ready) sel <= ~sel;
        default: ;
      endcase
    end
  end

  assign so_valid = (mode == M_STAT) || (mode == M_ID);

  always_comb begin
    case (mode)
      M_STAT:  so_data = status_byte;
      M_ID:    so_data = sel ? DEV_ID : MFR_ID;
      default: so_data = '0;
    endcase
  end

  // R2: a status opcode opens a stream in the next cycle
  p_stat_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_RDSR) |=> so_valid);

  // R10: each accepted ID byte flips the selection
  p_id_alternates_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ID && so_ready && !op_valid && !cyc_end) |=> (sel != $past(sel)));

  // R11: back-pressure freezes the offered ID byte
  p_id_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ID && !so_ready && !op_valid && !cyc_end) |=> (so_valid && $stable(so_data)));

  // R12: end of cycle silences the stream
  p_end_silences_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && !op_valid) |=> !so_valid);
endmodule

// File: rtl/fsr_id_responder.sv
module fsr_id_responder #(
  parameter logic [7:0]        MFR_ID     = 8'h5A,
  parameter logic [7:0]        DEV_ID     = 8'h43,
  parameter int unsigned       PROT_W     = 4,
  parameter logic [PROT_W-1:0] PROT_RST   = '1,
  parameter int unsigned       ADDR_BYTES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [7:0]        op_code,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              cyc_end,
  input  logic              busy_in,
  input  logic              wel_in,
  output logic              so_valid,
  input  logic              so_ready,
  output logic [7:0]        so_data,
  output logic [PROT_W-1:0] prot_bits
);
  logic       commit;
  logic [7:0] commit_data;
  logic [7:0] status_byte;

  fsr_wsr_guard u_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_code     (op_code),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .cyc_end     (cyc_end),
    .commit      (commit),
    .commit_data (commit_data)
  );

  fsr_sr_regs #(.PROT_W(PROT_W), .PROT_RST(PROT_RST)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit),
    .commit_data (commit_data),
    .busy_in     (busy_in),
    .wel_in      (wel_in),
    .prot        (prot_bits),
    .status_byte (status_byte)
  );

  fsr_rsp_stream #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .ADDR_BYTES(ADDR_BYTES)) u_stream (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_code     (op_code),
    .in_valid    (in_valid),
    .in_a0       (in_data[0]),
    .cyc_end     (cyc_end),
    .status_byte (status_byte),
    .so_ready    (so_ready),
    .so_valid    (so_valid),
    .so_data     (so_data)
  );
endmodule

// File: tb/fsr_id_responder_tb_top.sv
`timescale 1ns/1ps
module fsr_id_responder_tb_top;
  localparam logic [7:0] MFR = 8'hA6;
  localparam logic [7:0] DEV = 8'h43;
  localparam int PW = 5;
  localparam logic [PW-1:0] PRST = 5'b10101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [7:0] op_code = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic cyc_end = 1'b0;
  logic busy_in = 1'b0;
  logic wel_in = 1'b0;
  logic so_ready = 1'b0;
  logic so_valid;
  logic [7:0] so_data;
  logic [PW-1:0] prot_bits;

  always #10 clk = ~clk;

  fsr_id_responder #(.MFR_ID(MFR), .DEV_ID(DEV), .PROT_W(PW), .PROT_RST(PRST)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .in_valid(in_valid), .in_data(in_data), .cyc_end(cyc_end),
    .busy_in(busy_in), .wel_in(wel_in), .so_valid(so_valid),
    .so_ready(so_ready), .so_data(so_data), .prot_bits(prot_bits)
  );

  int total = 0;
  int fails = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [PW-1:0] exp_prot;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every handshake
  always @(negedge clk) begin
    if (rst_n && so_valid && so_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected byte", so_data, 0);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(so_data == e, t, so_data, e);
      end
    end
  end

  task automatic tick(); @(posedge clk); #2; endtask
  task automatic begin_op(input logic [7:0] op);
    op_valid = 1'b1; op_code = op; tick(); op_valid = 1'b0;
  endtask
  task automatic push_in(input logic [7:0] b);
    in_valid = 1'b1; in_data = b; tick(); in_valid = 1'b0;
  endtask
  task automatic end_cyc();
    so_ready = 1'b0; cyc_end = 1'b1; tick(); cyc_end = 1'b0;
  endtask
  task automatic pull_status(input int n);
    for (int i = 0; i < n; i++) begin
      busy_in = i[0]; wel_in = i[1];
      exp_q.push_back({1'b0, exp_prot, i[1], i[0]});
      tag_q.push_back("R2 R3 status byte");
      so_ready = 1'b1; tick();
    end
    so_ready = 1'b0;
  endtask
  task automatic pull_id(input int n, inout logic sel);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(sel ? DEV : MFR);
      tag_q.push_back("R9 R10 id byte");
      so_ready = 1'b1; tick(); sel = ~sel;
    end
    so_ready = 1'b0;
  endtask
  task automatic check_prot(input string tag);
    #5 check(prot_bits == exp_prot, tag, prot_bits, exp_prot);
  endtask

  initial begin
    #4_000_000;
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic sel;
    logic [7:0] held;
    exp_prot = PRST;
    #45 rst_n = 1'b1;
    tick();
    // R1
    check(so_valid == 1'b0, "R1 so_valid after reset", so_valid, 0);
    check(prot_bits == PRST, "R1 prot after reset", prot_bits, PRST);

    // R2, R3: status stream with changing flags; R12 after end
    begin_op(8'h05);
    pull_status(4);
    end_cyc();
    #5 check(so_valid == 1'b0, "R12 idle after end", so_valid, 0);
    check(exp_q.size() == 0, "R2 all status bytes seen", exp_q.size(), 0);

    // R5: write without enable
    tick(); begin_op(8'h01); push_in(8'hFF); end_cyc();
    check_prot("R5 unenabled write ignored");

    // R4, R7: enabled write, second byte ignored
    begin_op(8'h50); end_cyc();
    begin_op(8'h01); push_in(8'h67); push_in(8'h00); end_cyc();
    exp_prot = 5'b11001;
    check_prot("R4 enabled write lands");
    check_prot("R7 second byte ignored");
    begin_op(8'h05); pull_status(4); end_cyc();   // R7: flags still live

    // R6: intervening command cancels
    begin_op(8'h50); end_cyc();
    begin_op(8'h05); end_cyc();
    begin_op(8'h01); push_in(8'h00); end_cyc();
    check_prot("R6 cancelled permission");

    // R8: granted cycle with no data consumes permission
    begin_op(8'h50); end_cyc();
    begin_op(8'h01); end_cyc();
    check_prot("R8 empty write no change");
    begin_op(8'h01); push_in(8'h00); end_cyc();
    check_prot("R8 permission used up");

    // R9, R10, R11: ID with A0 = 0 and back-pressure
    begin_op(8'h90); push_in(8'h00); push_in(8'h00);
    #5 check(so_valid == 1'b0, "R9 no stream during address", so_valid, 0);
    #0 push_in(8'h00);
    sel = 1'b0;
    pull_id(3, sel);
    #5 held = so_data;
    for (int k = 0; k < 3; k++) begin
      tick();
      #5 check(so_valid && so_data == held, "R11 held under back-pressure", so_data, held);
    end
    check(held == (sel ? DEV : MFR), "R11 no advance while stalled", held, sel ? DEV : MFR);
    tick();
    pull_id(2, sel);
    end_cyc();
    #5 check(so_valid == 1'b0, "R12 id stream ends", so_valid, 0);

    // R9: A0 = 1 starts with device ID
    begin_op(8'h90); push_in(8'h00); push_in(8'h00); push_in(8'h01);
    sel = 1'b1;
    pull_id(3, sel);
    end_cyc();

    // R12: other opcode gives no stream
    begin_op(8'h03);
    #5 check(so_valid == 1'b0, "R12 other opcode silent", so_valid, 0);
    tick(); end_cyc();
    tick();
    check(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule